// File: doc/BRIEF.md
# Multicycle Instruction Cycle Sequencer

This block is the control sequencer of a small accumulator machine that runs each instruction as a series of single-clock register transfers. An instruction moves through a fetch phase, an optional indirect phase, an execute phase and an interrupt-check phase. Every memory access goes through the memory address register (MAR) and the memory buffer register (MBR). The program counter (PC) and instruction register (IR) are held alongside them. A single-port synchronous memory returns read data one clock after the read strobe. Each state that issues a read is followed by exactly one state that captures the returned word.

An instruction word is `DATA_W` bits wide. The top 4 bits are the opcode and the next bit flags indirect addressing. The low `ADDR_W = DATA_W - 5` bits are an address. An interrupt request is looked at only once per instruction, in the check state after execute. When it is taken, the sequencer saves the return PC at the stack location, moves the stack pointer down by one and continues at a fixed handler address.

Top module: `instrSequencer`

## Requirements
- R1: While `rstN` is low, PC and accumulator read zero and no strobe or acknowledge is active. The first read after reset is at address 0, issued in the second cycle after release.
- R2: A fetch reads memory at the PC. The PC advances by one in the cycle the read is issued. The fetched word appears on `irOut` once the instruction has been decoded.
- R3: For an address-using opcode (LOAD=1, STORE=2, ADD=3, SUB=4, AND=5, JMP=6) with bit `ADDR_W` set, one extra read at the address field takes place. The low `ADDR_W` bits of the word it returns become the effective address.
- R4: The indirect bit has no effect on register-only opcodes (NOP=0, CLR=7, NOT=8): no extra memory access takes place.
- R5: LOAD, ADD, SUB and AND read the operand at the effective address. They then set the accumulator to the operand, or to the sum, difference or bitwise AND, taken modulo 2^`DATA_W`.
- R6: STORE writes the accumulator to the effective address with a single-cycle write strobe.
- R7: JMP sets the PC to the effective address.
- R8: CLR zeroes the accumulator and NOT inverts it, with no memory access.
- R9: An interrupt request is acted on only in the check state that follows execute. A request that is low in that cycle is not taken, even if it was high earlier in the instruction.
- R10: A taken interrupt writes the return PC, zero-extended, to the address held in the stack pointer (reset value `SP_INIT`). The stack pointer then decrements. The next fetch reads `HANDLER_ADDR`.
- R11: `irqAck` is a one-cycle pulse in the cycle the PC is loaded with `HANDLER_ADDR`.
- R12: `memRd` and `memWr` are never high together.
- R13: Opcodes 9 to 15 behave as NOP, whatever the indirect bit holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| memAddr | output | ADDR_W | Memory address (driven from MAR) |
| memRd | output | 1 | Memory read strobe |
| memWr | output | 1 | Memory write strobe |
| memRdData | input | DATA_W | Read data, valid one clock after `memRd` |
| memWrData | output | DATA_W | Write data (driven from MBR) |
| irqReq | input | 1 | Interrupt request level |
| irqAck | output | 1 | Interrupt acknowledge pulse |
| pcOut | output | ADDR_W | Current PC |
| accOut | output | DATA_W | Current accumulator |
| irOut | output | DATA_W | Current instruction register |

## Verification
The bench keeps `DATA_W` at 16, which gives an 11-bit address space and a bench memory of 2048 words. It moves the handler to 0x300 and starts the stack at 0x7F0, so the checks show that both settings are honoured rather than fixed. With these values the program fits in low memory, the handler sits in the middle and the descending stack stays in high memory. This lets repeated interrupts, an indirect jump and the ADD that wraps around 2^16 all run in one program without overwriting each other.

// File: rtl/seqPkg.sv
package seqPkg;

  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OP_NOP   = 4'd0;
  localparam logic [OPC_W-1:0] OP_LOAD  = 4'd1;
  localparam logic [OPC_W-1:0] OP_STORE = 4'd2;
  localparam logic [OPC_W-1:0] OP_ADD   = 4'd3;
  localparam logic [OPC_W-1:0] OP_SUB   = 4'd4;
  localparam logic [OPC_W-1:0] OP_AND   = 4'd5;
  localparam logic [OPC_W-1:0] OP_JMP   = 4'd6;
  localparam logic [OPC_W-1:0] OP_CLR   = 4'd7;
  localparam logic [OPC_W-1:0] OP_NOT   = 4'd8;

  typedef enum logic [3:0] {
    S_FETCH0, S_FETCH1, S_FETCH2, S_DECODE,
    S_IND1, S_IND2, S_IND3,
    S_EXEC0, S_EXEC1, S_EXEC2, S_STORE,
    S_INTCHK, S_INT0, S_INT1, S_INT2
  } seqState_t;

  typedef enum logic [2:0] {
    ACC_HOLD, ACC_LOAD, ACC_ADD, ACC_SUB, ACC_AND, ACC_CLR, ACC_NOT
  } accOp_t;

  typedef struct packed {
    logic   marFromPc;
    logic   marFromMbr;
    logic   marFromSp;
    logic   pcInc;
    logic   pcFromMar;
    logic   pcFromHandler;
    logic   mbrFromMem;
    logic   mbrFromAcc;
    logic   mbrFromPc;
    logic   irFromMbr;
    logic   spDec;
    logic   memRd;
    logic   memWr;
    accOp_t accOp;
  } seqStrobes_t;

  function automatic logic usesAddr(input logic [OPC_W-1:0] op);
    return (op == OP_LOAD) || (op == OP_STORE) || (op == OP_ADD) ||
           (op == OP_SUB)  || (op == OP_AND)   || (op == OP_JMP);
  endfunction

  function automatic logic readsOperand(input logic [OPC_W-1:0] op);
    return (op == OP_LOAD) || (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND);
  endfunction

endpackage

// File: rtl/seqAlu.sv
module seqAlu
  import seqPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  accOp_t             op,
  input  logic [DATA_W-1:0]  accIn,
  input  logic [DATA_W-1:0]  operand,
  output logic [DATA_W-1:0]  result
);
  always_comb begin
    unique case (op)
      ACC_LOAD: result = operand;
      ACC_ADD:  result = accIn + operand;
      ACC_SUB:  result = accIn - operand;
      ACC_AND:  result = accIn & operand;
      ACC_CLR:  result = '0;
      ACC_NOT:  result = ~accIn;
      default:  result = accIn;
    endcase
  end
endmodule

// File: rtl/seqDatapath.sv
module seqDatapath
  import seqPkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int ADDR_W       = 11,
  parameter int HANDLER_ADDR = 'h400,
  parameter int SP_INIT      = 'h7FF
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  input  logic [DATA_W-1:0] memRdData,
  output logic [ADDR_W-1:0] marQ,
  output logic [DATA_W-1:0] mbrQ,
  output logic [ADDR_W-1:0] pcQ,
  output logic [DATA_W-1:0] accQ,
  output logic [DATA_W-1:0] irQ
);
  localparam logic [ADDR_W-1:0] HANDLER_VEC = ADDR_W'(HANDLER_ADDR);
  localparam logic [ADDR_W-1:0] SP_RESET    = ADDR_W'(SP_INIT);
  localparam int                PAD_W       = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] spQ;
  logic [DATA_W-1:0] aluResult;

  seqAlu #(.DATA_W(DATA_W)) uAlu (
    .op      (strobes.accOp),
    .accIn   (accQ),
    .operand (mbrQ),
    .result  (aluResult)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      marQ <= '0;
      mbrQ <= '0;
      pcQ  <= '0;
      accQ <= '0;
      irQ  <= '0;
      spQ  <= SP_RESET;
    end else begin
      if (strobes.marFromPc)       marQ <= pcQ;
      else if (strobes.marFromMbr) marQ <= mbrQ[ADDR_W-1:0];
      else if (strobes.marFromSp)  marQ <= spQ;

      if (strobes.pcFromHandler)   pcQ <= HANDLER_VEC;
      else if (strobes.pcFromMar)  pcQ <= marQ;
      else if (strobes.pcInc)      pcQ <= pcQ + 1'b1;

      if (strobes.mbrFromMem)      mbrQ <= memRdData;
      else if (strobes.mbrFromAcc) mbrQ <= accQ;
      else if (strobes.mbrFromPc)  mbrQ <= {{PAD_W{1'b0}}, pcQ};

      if (strobes.irFromMbr)       irQ <= mbrQ;
      if (strobes.accOp != ACC_HOLD) accQ <= aluResult;
      if (strobes.spDec)           spQ <= spQ - 1'b1;
    end
  end
endmodule

// File: rtl/seqControl.sv
module seqControl
  import seqPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             irqReq,
  input  logic [OPC_W-1:0] mbrOpcode,
  input  logic             mbrIndirect,
  input  logic [OPC_W-1:0] irOpcode,
  output seqStrobes_t      strobes,
  output logic             irqAck,
  output seqState_t        curState
);
  seqState_t nextState;

  always_ff @(posedge clk) begin
    if (!rstN) curState <= S_FETCH0;
    else       curState <= nextState;
  end

  function automatic accOp_t opToAcc(input logic [OPC_W-1:0] op);
    unique case (op)
      OP_LOAD: return ACC_LOAD;
      OP_ADD:  return ACC_ADD;
      OP_SUB:  return ACC_SUB;
      OP_AND:  return ACC_AND;
      OP_CLR:  return ACC_CLR;
      OP_NOT:  return ACC_NOT;
      default: return ACC_HOLD;
    endcase
  endfunction

  always_comb begin
    strobes   = '0;
    irqAck    = 1'b0;
    nextState = curState;
    unique case (curState)
      S_FETCH0: begin
        strobes.marFromPc = 1'b1;
        nextState = S_FETCH1;
      end
      S_FETCH1: begin
        strobes.memRd = 1'b1;
        strobes.pcInc = 1'b1;
        nextState = S_FETCH2;
      end
      S_FETCH2: begin
        strobes.mbrFromMem = 1'b1;
        nextState = S_DECODE;
      end
      S_DECODE: begin
        strobes.irFromMbr  = 1'b1;
        strobes.marFromMbr = 1'b1;
        nextState = (usesAddr(mbrOpcode) && mbrIndirect) ? S_IND1 : S_EXEC0;
      end
      S_IND1: begin
        strobes.memRd = 1'b1;
        nextState = S_IND2;
      end
      S_IND2: begin
        strobes.mbrFromMem = 1'b1;
        nextState = S_IND3;
      end
      S_IND3: begin
        strobes.marFromMbr = 1'b1;
        nextState = S_EXEC0;
      end
      S_EXEC0: begin
        if (readsOperand(irOpcode)) begin
          strobes.memRd = 1'b1;
          nextState = S_EXEC1;
        end else if (irOpcode == OP_STORE) begin
          strobes.mbrFromAcc = 1'b1;
          nextState = S_STORE;
        end else begin
          strobes.pcFromMar = (irOpcode == OP_JMP);
          strobes.accOp     = ((irOpcode == OP_CLR) || (irOpcode == OP_NOT)) ?
                              opToAcc(irOpcode) : ACC_HOLD;
          nextState = S_INTCHK;
        end
      end
      S_EXEC1: begin
        strobes.mbrFromMem = 1'b1;
        nextState = S_EXEC2;
      end
      S_EXEC2: begin
        strobes.accOp = opToAcc(irOpcode);
        nextState = S_INTCHK;
      end
      S_STORE: begin
        strobes.memWr = 1'b1;
        nextState = S_INTCHK;
      end
      S_INTCHK: begin
        nextState = irqReq ? S_INT0 : S_FETCH0;
      end
      S_INT0: begin
        strobes.mbrFromPc = 1'b1;
        strobes.marFromSp = 1'b1;
        nextState = S_INT1;
      end
      S_INT1: begin
        strobes.memWr = 1'b1;
        strobes.spDec = 1'b1;
        nextState = S_INT2;
      end
      S_INT2: begin
        strobes.pcFromHandler = 1'b1;
        irqAck = 1'b1;
        nextState = S_FETCH0;
      end
      default: nextState = S_FETCH0;
    endcase
  end
endmodule

// File: rtl/instrSequencer.sv
module instrSequencer
  import seqPkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int HANDLER_ADDR = 'h400,
  parameter int SP_INIT      = 'h7FF,
  localparam int ADDR_W      = DATA_W - OPC_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic              memWr,
  input  logic [DATA_W-1:0] memRdData,
  output logic [DATA_W-1:0] memWrData,
  input  logic              irqReq,
  output logic              irqAck,
  output logic [ADDR_W-1:0] pcOut,
  output logic [DATA_W-1:0] accOut,
  output logic [DATA_W-1:0] irOut
);
  localparam int IND_BIT = ADDR_W;

  seqStrobes_t       strobes;
  seqState_t         curState;
  logic [DATA_W-1:0] mbrQ;

  seqControl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .irqReq      (irqReq),
    .mbrOpcode   (mbrQ[DATA_W-1 -: OPC_W]),
    .mbrIndirect (mbrQ[IND_BIT]),
    .irOpcode    (irOut[DATA_W-1 -: OPC_W]),
    .strobes     (strobes),
    .irqAck      (irqAck),
    .curState    (curState)
  );

  seqDatapath #(
    .DATA_W       (DATA_W),
    .ADDR_W       (ADDR_W),
    .HANDLER_ADDR (HANDLER_ADDR),
    .SP_INIT      (SP_INIT)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .memRdData (memRdData),
    .marQ      (memAddr),
    .mbrQ      (mbrQ),
    .pcQ       (pcOut),
    .accQ      (accOut),
    .irQ       (irOut)
  );

  assign memRd     = strobes.memRd;
  assign memWr     = strobes.memWr;
  assign memWrData = mbrQ;
endmodule

// File: rtl/instrSequencerChecker.sv
module instrSequencerChecker
  import seqPkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int ADDR_W       = 11,
  parameter int HANDLER_ADDR = 'h400
) (
  input logic              clk,
  input logic              rstN,
  input logic              memRd,
  input logic              memWr,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWrData,
  input logic              irqAck,
  input logic [ADDR_W-1:0] pcOut,
  input seqState_t         curState
);
  localparam logic [ADDR_W-1:0] HANDLER_VEC = ADDR_W'(HANDLER_ADDR);

  a_r12_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));

  a_r2_fetch_at_pc: assert property (@(posedge clk) disable iff (!rstN)
    (curState == S_FETCH1) |-> (memRd && memAddr == pcOut));

  a_r2_pc_step: assert property (@(posedge clk) disable iff (!rstN)
    (curState == S_FETCH1) |=> (pcOut == $past(pcOut) + 1'b1));

  a_r3_ind_read: assert property (@(posedge clk) disable iff (!rstN)
    (curState == S_IND1) |-> memRd);

  a_r9_int_after_check: assert property (@(posedge clk) disable iff (!rstN)
    (curState == S_INT0) |-> ($past(curState) == S_INTCHK));

  a_r10_save_pc: assert property (@(posedge clk) disable iff (!rstN)
    (curState == S_INT1) |-> (memWr && memWrData[ADDR_W-1:0] == pcOut));

  a_r11_ack_pulse: assert property (@(posedge clk) disable iff (!rstN)
    irqAck |=> !irqAck);

  a_r11_ack_handler: assert property (@(posedge clk) disable iff (!rstN)
    irqAck |=> (pcOut == HANDLER_VEC));
endmodule

bind instrSequencer instrSequencerChecker #(
  .DATA_W       (DATA_W),
  .ADDR_W       (ADDR_W),
  .HANDLER_ADDR (HANDLER_ADDR)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .memRd     (memRd),
  .memWr     (memWr),
  .memAddr   (memAddr),
  .memWrData (memWrData),
  .irqAck    (irqAck),
  .pcOut     (pcOut),
  .curState  (curState)
);

// File: tb/instrSequencer_test.sv
`timescale 1ns/100ps
module instrSequencer_test;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = DATA_W - 5;
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int HANDLER = 'h300;
  localparam int SP0     = 'h7F0;
  localparam int RUN_CYC = 4000;

  typedef struct packed {
    logic              rd, wr, ack, chk;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] eAcc;
    logic [ADDR_W-1:0] ePc;
    logic [DATA_W-1:0] eIr;
  } busEnt_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ADDR_W-1:0] memAddr;
  logic memRd, memWr, irqAck;
  logic [DATA_W-1:0] memRdData = '0;
  logic [DATA_W-1:0] memWrData;
  logic irqReq = 1'b0;
  logic [ADDR_W-1:0] pcOut;
  logic [DATA_W-1:0] accOut, irOut;

  always #2.5 clk = ~clk;

  instrSequencer #(.DATA_W(DATA_W), .HANDLER_ADDR(HANDLER), .SP_INIT(SP0)) uut (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memRd(memRd), .memWr(memWr),
    .memRdData(memRdData), .memWrData(memWrData), .irqReq(irqReq),
    .irqAck(irqAck), .pcOut(pcOut), .accOut(accOut), .irOut(irOut));

  logic [DATA_W-1:0] ram    [DEPTH];
  logic [DATA_W-1:0] refMem [DEPTH];

  always @(posedge clk) begin
    if (memWr) ram[memAddr] <= memWrData;
    if (memRd) memRdData <= ram[memAddr];
  end

  int checks = 0;
  int errors = 0;
  bit running = 0;
  bit started = 0;
  busEnt_t expQ[$];
  string   tagQ[$];

  logic [ADDR_W-1:0] mPc = '0;
  logic [ADDR_W-1:0] mSp = ADDR_W'(SP0);
  logic [DATA_W-1:0] mAcc = '0;
  logic [DATA_W-1:0] mIr = '0;
  string lastTag = "R2";

  function automatic logic [DATA_W-1:0] enc(int op, int ind, int addr);
    return {4'(op), 1'(ind), ADDR_W'(addr)};
  endfunction

  task automatic pushBus(input logic rd, input logic wr, input logic ack,
                         input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                         input string tag);
    busEnt_t e;
    e = '0;
    e.rd = rd; e.wr = wr; e.ack = ack; e.addr = a; e.wdata = d;
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  task automatic pushIdle(input string tag);
    pushBus(1'b0, 1'b0, 1'b0, '0, '0, tag);
  endtask

  task automatic pushCheck(input string tag);
    busEnt_t e;
    e = '0;
    e.chk = 1'b1; e.eAcc = mAcc; e.ePc = mPc; e.eIr = mIr;
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  // Behavioural model: emits the expected bus activity of the check cycle
  // that closes the previous instruction, then of the next instruction.
  task automatic genChunk();
    logic [DATA_W-1:0] instr, opnd;
    logic [3:0] op;
    logic ind;
    logic [ADDR_W-1:0] fld, ea;
    bit addrOp;
    if (started) begin
      pushCheck(lastTag);
      if (irqReq) begin
        pushIdle("R9");
        pushBus(1'b0, 1'b1, 1'b0, mSp, DATA_W'(mPc), "R10");
        pushBus(1'b0, 1'b0, 1'b1, '0, '0, "R11");
        mSp = mSp - 1'b1;
        mPc = ADDR_W'(HANDLER);
      end
    end
    pushIdle(started ? "R2" : "R1");
    pushBus(1'b1, 1'b0, 1'b0, mPc, '0, started ? "R2" : "R1");
    pushIdle("R2");
    pushIdle("R2");
    started = 1;
    instr = refMem[mPc];
    mPc = mPc + 1'b1;
    op = instr[DATA_W-1 -: 4];
    ind = instr[ADDR_W];
    fld = instr[ADDR_W-1:0];
    addrOp = (op >= 4'd1) && (op <= 4'd6);
    ea = fld;
    if (addrOp && ind) begin
      pushBus(1'b1, 1'b0, 1'b0, fld, '0, "R3");
      pushIdle("R3");
      pushIdle("R3");
      ea = refMem[fld][ADDR_W-1:0];
    end
    case (op)
      4'd1, 4'd3, 4'd4, 4'd5: begin
        pushBus(1'b1, 1'b0, 1'b0, ea, '0, "R5");
        pushIdle("R5");
        pushIdle("R5");
        opnd = refMem[ea];
        case (op)
          4'd1:    mAcc = opnd;
          4'd3:    mAcc = mAcc + opnd;
          4'd4:    mAcc = mAcc - opnd;
          default: mAcc = mAcc & opnd;
        endcase
        lastTag = "R5";
      end
      4'd2: begin
        pushIdle("R6");
        pushBus(1'b0, 1'b1, 1'b0, ea, mAcc, "R6");
        refMem[ea] = mAcc;
        lastTag = "R6";
      end
      4'd6: begin
        pushIdle("R7");
        mPc = ea;
        lastTag = "R7";
      end
      4'd7, 4'd8: begin
        lastTag = ind ? "R4" : "R8";
        pushIdle(lastTag);
        mAcc = (op == 4'd7) ? '0 : ~mAcc;
      end
      4'd0: begin
        lastTag = ind ? "R4" : "R8";
        pushIdle(lastTag);
      end
      default: begin
        lastTag = "R13";
        pushIdle("R13");
      end
    endcase
    mIr = instr;
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  int sinceRead = 0;

  always @(negedge clk) begin
    busEnt_t e;
    string t;
    if (running) begin
      if (expQ.size() == 0) genChunk();
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if (memRd !== e.rd || memWr !== e.wr || irqAck !== e.ack ||
          ((e.rd || e.wr) && memAddr !== e.addr) ||
          (e.wr && memWrData !== e.wdata)) begin
        errors++;
        $display("FAIL %s bus: rd=%b wr=%b ack=%b addr=%h wdata=%h, expected rd=%b wr=%b ack=%b addr=%h wdata=%h",
                 t, memRd, memWr, irqAck, memAddr, memWrData,
                 e.rd, e.wr, e.ack, e.addr, e.wdata);
      end
      if (e.chk) begin
        checks++;
        if (accOut !== e.eAcc || pcOut !== e.ePc || irOut !== e.eIr) begin
          errors++;
          $display("FAIL %s regs: acc=%h pc=%h ir=%h, expected acc=%h pc=%h ir=%h",
                   t, accOut, pcOut, irOut, e.eAcc, e.ePc, e.eIr);
        end
      end
      checks++;
      if (memRd && memWr) begin
        errors++;
        $display("FAIL R12 strobes: rd=%b wr=%b, expected not both", memRd, memWr);
      end
      sinceRead = memRd ? 0 : sinceRead + 1;
      if (sinceRead > 64) begin
        checks++;
        errors++;
        $display("FAIL watchdog: %0d cycles without a read, expected at most 64", sinceRead);
        finishRun();
      end
    end
  end

  // Interrupt stimulus: held requests are kept until acknowledged; every
  // third one is a single-cycle pulse that may fall outside the check state.
  initial begin
    wait (running);
    for (int k = 0; k < 12; k++) begin
      repeat (41 + k * 29) @(posedge clk);
      #1 irqReq = 1'b1;
      if (k % 3 == 2) begin
        @(posedge clk);
        #1 irqReq = 1'b0;
      end else begin
        do @(negedge clk); while (!irqAck);
        @(posedge clk);
        #1 irqReq = 1'b0;
      end
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      ram[i] = '0;
    end
    ram[0]   = enc(1, 0, 100);
    ram[1]   = enc(3, 0, 101);
    ram[2]   = enc(4, 1, 102);
    ram[3]   = enc(5, 0, 104);
    ram[4]   = enc(2, 0, 200);
    ram[5]   = enc(2, 1, 105);
    ram[6]   = enc(8, 0, 0);
    ram[7]   = enc(7, 1, 100);
    ram[8]   = enc(1, 0, 200);
    ram[9]   = enc(15, 1, 100);
    ram[10]  = enc(0, 1, 101);
    ram[11]  = enc(6, 1, 106);
    ram[20]  = enc(8, 0, 0);
    ram[21]  = enc(3, 0, 100);
    ram[22]  = enc(6, 0, 0);
    ram[100] = 16'h1234;
    ram[101] = 16'hF00F;
    ram[102] = 16'd103;
    ram[103] = 16'd5;
    ram[104] = 16'h0FF7;
    ram[105] = 16'd201;
    ram[106] = 16'd20;
    ram[HANDLER]     = enc(8, 0, 0);
    ram[HANDLER + 1] = enc(3, 0, 101);
    ram[HANDLER + 2] = enc(6, 0, 8);
    for (int i = 0; i < DEPTH; i++) begin
      refMem[i] = ram[i];
    end

    repeat (3) @(negedge clk);
    checks++;
    if (memRd !== 1'b0 || memWr !== 1'b0 || irqAck !== 1'b0 ||
        pcOut !== '0 || accOut !== '0) begin
      errors++;
      $display("FAIL R1 reset: rd=%b wr=%b ack=%b pc=%h acc=%h, expected all zero",
               memRd, memWr, irqAck, pcOut, accOut);
    end
    @(posedge clk);
    #1 rstN = 1'b1;
    running = 1;
    repeat (RUN_CYC) @(posedge clk);
    #1 running = 0;
    finishRun();
  end
endmodule